// File: doc/BRIEF.md
# Serial-Loaded Crosspoint Switch Controller

This block is the digital control for an analog crosspoint mixer with `NUM_IN` inputs and `NUM_OUT` outputs, one on/off enable per input-output pair. The controller takes the switch pattern one bit at a time from a serial data pin. It captures a bit on each rising edge of a separate shift clock. A level-sensitive load strobe then copies the assembled pattern onto the switch enables. While the strobe is high the applied pattern follows the shift chain, so shifting during that time alters the switches.

A power-save input overrides everything else. It forces exactly two paths on, input 1 to output 1 and input 2 to output 2, and turns every other switch off. When power-save is released, the forced pattern stays in place until a fresh pattern is loaded with the strobe. The controller counts shift edges since the last strobe. A strobe that arrives after any count other than the full chain length still applies, but it raises a load-error flag. The default parameters give an 8x8, 64-switch array. Setting both dimensions to 4 gives the reduced 16-switch form, whose forced paths fall on switches S1 and S6.

All inputs are assumed synchronous to `clk`. The shift clock is treated as a data level, sampled by `clk`, and must stay low or high for at least one `clk` cycle per phase.

Top module: `xbar_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all switch enables are 0, `ps_active` is 0 and `load_err` is 0.
- R2: Switch Sn, for input i and output j (both counted from 1), has index n = NUM_OUT*(i-1)+j and is driven on `sw_en[n-1]`, where 1 means on. After a full load, the first bit shifted in lands on the highest-numbered switch and the last bit lands on S1.
- R3: A bit on `ser_data` is captured when `clk` first samples `shift_clk` high after sampling it low. After exactly NUM_IN*NUM_OUT captures, the cycle that samples `load_strobe` high applies the chain to `sw_en` at the next edge, and `load_err` is 0.
- R4: While `load_strobe` is held high, every further capture shows up on `sw_en` one cycle after the chain changes.
- R5: When `load_strobe` rises after a capture count other than NUM_IN*NUM_OUT, fewer or more, `load_err` goes to 1 and the chain is still applied. The next rise after a full-length load clears `load_err`.
- R6: Captures made while `load_strobe` is low leave `sw_en` unchanged.
- R7: One cycle after `pwr_save` is sampled high, only the S1 and S(NUM_OUT+2) enables are 1 and `ps_active` is 1.
- R8: After `pwr_save` goes low, `sw_en` keeps the forced pattern and `ps_active` stays 1 until `load_strobe` is sampled high. Captures made in the meantime do not change `sw_en`.
- R9: A strobe sampled while `pwr_save` is high does not change `sw_en`.
- R10: With NUM_IN = NUM_OUT = 4, a full load is 16 captures and the forced pattern is S1 and S6, which is `sw_en` value 16'h0021.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_data | input | 1 | Serial pattern bit |
| shift_clk | input | 1 | Shift clock level; a rising edge captures `ser_data` |
| load_strobe | input | 1 | Level strobe; while high, the chain drives the switch state |
| pwr_save | input | 1 | Forces the two default paths while high |
| sw_en | output | NUM_IN*NUM_OUT | Switch enables, bit n-1 for Sn, 1 = on |
| ps_active | output | 1 | Forced power-save pattern is driving the switches |
| load_err | output | 1 | Last strobe followed a wrong capture count |

## Verification
The bench loads loads of 63 and 65 bits. A counter that compares only a lower bound, or that wraps, would miss one of them and leave `load_err` low. It releases power-save and then shifts in a full pattern without a strobe, which catches a design that drops back to the stored pattern or lets captures through. It also strobes during power-save and shifts while the strobe is held high. A design that treats the strobe as an edge would freeze the switches, and one that ignores the override priority would show the new pattern early. A lone switch at input 3, output 5 and the 4x4 instance pin down the bit ordering and the placement of the forced paths, which an off-by-one index or reversed shift direction would break.

// File: rtl/xbar_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the crosspoint controller.
// Assumes switch numbering is input-major, both indices counted from 1.
package xbar_pkg;
    // Number of paths forced on during power save (input k to output k).
    localparam int PS_PATHS = 2;

    // Zero-based enable bit of the switch joining input in_idx to output out_idx.
    function automatic int sw_bit(input int num_out, input int in_idx, input int out_idx);
        return num_out * (in_idx - 1) + out_idx - 1;
    endfunction
endpackage

// File: rtl/xbar_edge_rise.sv
`timescale 1ns/1ps
// Rising-edge detector for a level that is synchronous to clk.
// Assumes the level is held for at least one clk cycle per phase.
module xbar_edge_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    // Remember the level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level && !prev_q;
endmodule

// File: rtl/xbar_shift_chain.sv
`timescale 1ns/1ps
// Serial shift chain plus a saturating count of captures since the last strobe.
// New bits enter at bit 0, so the first bit in ends at the top after NSW shifts.
module xbar_shift_chain #(
    parameter int NSW  = 64,
    parameter int CNTW = $clog2(NSW + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shift_en,
    input  logic            din,
    input  logic            clr_cnt,
    output logic [NSW-1:0]  chain,
    output logic [CNTW-1:0] cnt
);
    localparam logic [CNTW-1:0] CNT_SAT = CNTW'(NSW + 1);

    // Shift one bit in on each captured shift-clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        chain <= '0;
        else if (shift_en) chain <= {chain[NSW-2:0], din};
    end

    // Count captures, cleared while the strobe is high, held at NSW+1 once past it.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (clr_cnt)                   cnt <= '0;
        else if (shift_en && cnt < CNT_SAT) cnt <= cnt + 1'b1;
    end

    // R6
    chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(chain));
    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr_cnt && cnt < CNT_SAT) |=> cnt == $past(cnt) + 1'b1);
    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_SAT);
endmodule

// File: rtl/xbar_load_check.sv
`timescale 1ns/1ps
// Flags a strobe that follows a capture count other than the full chain length.
// The flag is sticky until the next strobe rise re-evaluates it.
module xbar_load_check #(
    parameter int NSW  = 64,
    parameter int CNTW = $clog2(NSW + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            strobe_rise,
    input  logic [CNTW-1:0] cnt,
    output logic            load_err
);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(NSW);

    // Judge the count once per strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)           load_err <= 1'b0;
        else if (strobe_rise) load_err <= (cnt != CNT_FULL);
    end

    // R3
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rise && cnt == CNT_FULL) |=> !load_err);
    // R5
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_rise && cnt != CNT_FULL) |=> load_err);
endmodule

// File: rtl/xbar_switch_state.sv
`timescale 1ns/1ps
// Switch-state latch with power-save override.
// The latch follows the chain while the strobe is high. Power save forces the default
// paths and the forced pattern stays until a strobe is seen with power save low.
module xbar_switch_state #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    localparam int NSW    = NUM_IN * NUM_OUT
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           strobe,
    input  logic           ps_req,
    input  logic [NSW-1:0] chain,
    output logic [NSW-1:0] sw_en,
    output logic           ps_active
);
    logic [NSW-1:0] latch_q;
    logic [NSW-1:0] def_mask;
    logic           hold_q;

    // Default pattern: switch (i, j) is on when i == j and i is within the forced paths.
    for (genvar gi = 1; gi <= NUM_IN; gi++) begin : g_in
        for (genvar gj = 1; gj <= NUM_OUT; gj++) begin : g_out
            assign def_mask[xbar_pkg::sw_bit(NUM_OUT, gi, gj)] =
                (gi == gj) && (gi <= xbar_pkg::PS_PATHS);
        end
    end

    // Latch follows the chain for as long as the strobe stays high.
    always_ff @(posedge clk) begin
        if (!rst_n)      latch_q <= '0;
        else if (strobe) latch_q <= chain;
    end

    // Forced-pattern hold: set by power save, released by a strobe outside power save.
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= 1'b0;
        else if (ps_req) hold_q <= 1'b1;
        else if (strobe) hold_q <= 1'b0;
    end

    assign sw_en     = hold_q ? def_mask : latch_q;
    assign ps_active = hold_q;

    // R7
    ps_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_req |=> (sw_en == def_mask) && ps_active);
    // R7
    ps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ps_active |-> $countones(sw_en) == xbar_pkg::PS_PATHS);
    // R8
    ps_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ps_active && !ps_req && !strobe) |=> $stable(sw_en) && ps_active);
    // R3
    load_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ps_req && strobe) |=> (sw_en == $past(chain)) && !ps_active);
endmodule

// File: rtl/xbar_ctrl.sv
`timescale 1ns/1ps
// Top of the serial-loaded crosspoint controller.
// Assumes all inputs are synchronous to clk and that shift_clk phases last one clk or more.
module xbar_ctrl #(
    parameter int NUM_IN  = 8,
    parameter int NUM_OUT = 8,
    localparam int NSW    = NUM_IN * NUM_OUT,
    localparam int CNTW   = $clog2(NSW + 2)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_data,
    input  logic           shift_clk,
    input  logic           load_strobe,
    input  logic           pwr_save,
    output logic [NSW-1:0] sw_en,
    output logic           ps_active,
    output logic           load_err
);
    logic            shift_rise;
    logic            strobe_rise;
    logic [NSW-1:0]  chain;
    logic [CNTW-1:0] cnt;

    xbar_edge_rise u_shift_edge (
        .clk(clk), .rst_n(rst_n), .level(shift_clk), .rise(shift_rise)
    );

    xbar_edge_rise u_strobe_edge (
        .clk(clk), .rst_n(rst_n), .level(load_strobe), .rise(strobe_rise)
    );

    xbar_shift_chain #(.NSW(NSW), .CNTW(CNTW)) u_chain (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_rise), .din(ser_data),
        .clr_cnt(load_strobe), .chain(chain), .cnt(cnt)
    );

    xbar_load_check #(.NSW(NSW), .CNTW(CNTW)) u_check (
        .clk(clk), .rst_n(rst_n), .strobe_rise(strobe_rise), .cnt(cnt),
        .load_err(load_err)
    );

    xbar_switch_state #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_state (
        .clk(clk), .rst_n(rst_n), .strobe(load_strobe), .ps_req(pwr_save),
        .chain(chain), .sw_en(sw_en), .ps_active(ps_active)
    );

    // R9
    ps_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_save && $past(pwr_save)) |=> $stable(sw_en));
endmodule

// File: tb/sim_xbar_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver models the expected outputs and queues them,
// and the monitor pops and compares one item per clock after the edge.
module sim_xbar_ctrl;
    localparam int NSW = 64;
    localparam logic [63:0] DEF0 = 64'h0000_0000_0000_0201; // S1 and S10
    localparam logic [15:0] DEF1 = 16'h0021;                // S1 and S6

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_data = 1'b0, shift_clk = 1'b0, load_strobe = 1'b0, pwr_save = 1'b0;
    logic [63:0] sw0;
    logic [15:0] sw1;
    logic ps0, ps1, err0, err1;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    xbar_ctrl #(.NUM_IN(8), .NUM_OUT(8)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .shift_clk(shift_clk),
        .load_strobe(load_strobe), .pwr_save(pwr_save),
        .sw_en(sw0), .ps_active(ps0), .load_err(err0)
    );

    xbar_ctrl #(.NUM_IN(4), .NUM_OUT(4)) u1 (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .shift_clk(shift_clk),
        .load_strobe(load_strobe), .pwr_save(pwr_save),
        .sw_en(sw1), .ps_active(ps1), .load_err(err1)
    );

    typedef struct {
        logic [63:0] sw;
        logic        ps;
        logic        err;
        string       tag;
    } exp_t;
    exp_t q[$];

    // Behavioural model of u0 built from the requirements.
    logic [63:0] m_chain = '0, m_latch = '0;
    logic m_hold = 0, m_err = 0, m_psc = 0, m_pstr = 0;
    int m_cnt = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one clock of inputs, advance the model, optionally queue an expectation.
    task automatic cyc(input logic d, input logic sc, input logic st, input logic ps,
                       input bit chk, input string tag);
        bit srise, strise;
        exp_t e;
        @(negedge clk);
        ser_data = d; shift_clk = sc; load_strobe = st; pwr_save = ps;
        srise  = sc && !m_psc;
        strise = st && !m_pstr;
        if (strise) m_err = (m_cnt != NSW);
        if (st) m_latch = m_chain;
        if (ps) m_hold = 1;
        else if (st) m_hold = 0;
        if (st) m_cnt = 0;
        else if (srise && m_cnt < NSW + 1) m_cnt++;
        if (srise) m_chain = {m_chain[62:0], d};
        m_psc = sc; m_pstr = st;
        if (chk) begin
            e.sw = m_hold ? DEF0 : m_latch;
            e.ps = m_hold; e.err = m_err; e.tag = tag;
            q.push_back(e);
        end
    endtask

    // Shift n bits of v, highest first, so the first bit lands highest.
    task automatic load(input logic [63:0] v, input int n, input logic ps);
        for (int k = n - 1; k >= 0; k--) begin
            cyc(v[k], 1'b0, 1'b0, ps, 0, "");
            cyc(v[k], 1'b1, 1'b0, ps, 0, "");
        end
    endtask

    task automatic strobe(input logic ps, input string tag);
        cyc(1'b0, 1'b0, 1'b1, ps, 1, tag);
        cyc(1'b0, 1'b0, 1'b0, ps, 1, tag);
    endtask

    // Monitor: compare the oldest expectation just after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(sw0 == e.sw, {e.tag, " sw_en"}, sw0, e.sw);
                check(ps0 == e.ps, {e.tag, " ps_active"}, 64'(ps0), 64'(e.ps));
                check(err0 == e.err, {e.tag, " load_err"}, 64'(err0), 64'(e.err));
            end
        end
    end

    // Watchdog.
    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 1, "R1");                       // reset state

        load(64'hA5C3_0F1E_8421_7BDE, 64, 0);
        cyc(0, 0, 0, 0, 1, "R6");                       // no strobe yet: still off
        strobe(0, "R3");

        load(64'h1 << 20, 64, 0);                        // input 3 to output 5 is S21
        strobe(0, "R2");
        @(posedge clk); #1;
        check(sw0 == (64'h1 << 20), "R2 lone S21", sw0, 64'h1 << 20);

        load(64'h0123_4567_89AB_CDEF, 64, 0);
        cyc(0, 0, 0, 0, 1, "R6");
        strobe(0, "R3");

        load(64'hFFFF_0000_FFFF_0000, 63, 0);           // one short
        strobe(0, "R5");
        load(64'h0F0F_F0F0_3333_CCCC, 64, 0);
        strobe(0, "R5");                                 // cleared
        load(64'h5555_AAAA_5555_AAAA, 65, 0);           // one long
        strobe(0, "R5");

        load(64'h8000_0000_0000_0001, 64, 0);
        cyc(0, 0, 1, 0, 1, "R4");
        cyc(1, 0, 1, 0, 1, "R4");
        cyc(1, 1, 1, 0, 1, "R4");
        cyc(0, 0, 1, 0, 1, "R4");
        cyc(0, 1, 1, 0, 1, "R4");
        cyc(0, 0, 1, 0, 1, "R4");
        cyc(0, 0, 0, 0, 1, "R4");

        cyc(0, 0, 0, 1, 1, "R7");
        cyc(0, 0, 0, 1, 1, "R7");
        load(64'hDEAD_BEEF_0BAD_F00D, 64, 1);
        strobe(1, "R9");
        cyc(0, 0, 0, 0, 1, "R8");
        load(64'hC001_D00D_1234_5678, 64, 0);
        cyc(0, 0, 0, 0, 1, "R8");
        strobe(0, "R8");

        cyc(0, 0, 0, 1, 1, "R7");
        @(posedge clk); #1;
        check(sw1 == DEF1, "R10 forced S1/S6", 64'(sw1), 64'(DEF1));
        check(ps1 == 1'b1, "R10 ps_active", 64'(ps1), 64'h1);
        cyc(0, 0, 0, 0, 1, "R8");
        load(64'h3C5A, 16, 0);
        strobe(0, "R5");                                 // 16 captures is short for u0
        @(posedge clk); #1;
        check(sw1 == 16'h3C5A, "R10 16-bit load", 64'(sw1), 64'h3C5A);
        check(err1 == 1'b0, "R10 load_err", 64'(err1), 64'h0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule